// File: doc/BRIEF.md
# Fixed-Header UDP Frame Streamer

This block turns a byte stream from an upstream producer into a continuous train of Ethernet frames. It drives a byte-wide gigabit transmit interface with data, enable and error lines. It is intended for a point-to-point link on which every packet has the same shape. The addresses, ports and payload length are elaboration-time constants, so nearly all header bytes, including the IPv4 header checksum, are fixed values worked out at elaboration. Only the payload and the running CRC change from one frame to the next.

Each frame goes out in this order:

- preamble and start-of-frame delimiter;
- the constant header;
- exactly one frame's worth of payload, pulled through a ready/valid input;
- zero padding when the frame would otherwise be too short;
- the frame check sequence, computed byte by byte as the frame leaves.

A mode input selects full UDP/IPv4 framing or a bare Ethernet frame with a configurable EtherType. The producer raises a "frame available" flag only when it holds a whole payload. If the producer stops supplying data partway through a payload, the frame is cut short and marked with the error line.

Top module: `udp_frame_streamer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `gmii_tx_en`, `gmii_tx_er`, `gmii_txd` and `s_ready` are all zero.
- R2: Every frame opens with seven bytes of 0x55 followed by one 0xD5, and these eight bytes are left out of the CRC.
- R3: In UDP mode the 42 header bytes are sent in this order:
  - destination MAC, then source MAC;
  - EtherType 0x0800;
  - an IPv4 header made of 0x45, 0x00, total length 28+N, identification 0, flags/fragment 0x4000, TTL, protocol 17, the ones'-complement header checksum, source IP and destination IP;
  - source port, destination port, UDP length 8+N, and checksum 0x0000.
  
  All multi-byte fields are big-endian, and N is the payload length.
- R4: After the header, exactly N payload bytes are sent in the order they were accepted. `s_ready` is high only in cycles in which a payload byte can be taken.
- R5: The last four bytes are the complement of the reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF). The CRC covers every byte from the destination MAC through the last pad byte, and the result is sent least significant byte first.
- R6: In raw mode the header is 14 bytes: the two MAC addresses and then the configured EtherType, followed by the payload. Zero bytes are added so that the frame measures at least 60 bytes before the FCS.
- R7: A frame starts only while `frame_avail` is high. Otherwise `gmii_tx_en` stays low.
- R8: At least 12 idle cycles separate two frames. With `frame_avail` held high, the gap is exactly 12 cycles.
- R9: If `s_valid` is low in a payload cycle, that cycle is sent with both `gmii_tx_en` and `gmii_tx_er` high, and `gmii_tx_en` falls on the next cycle. `gmii_tx_er` is never high at any other time.
- R10: `cfg_raw` is sampled once, as a frame begins. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_avail | input | 1 | Producer holds a complete payload |
| cfg_raw | input | 1 | 1 = bare Ethernet frame, 0 = UDP/IPv4 frame |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte is valid |
| s_ready | output | 1 | Block takes a payload byte this cycle |
| gmii_txd | output | 8 | Transmit byte to the PHY |
| gmii_tx_en | output | 1 | Transmit enable |
| gmii_tx_er | output | 1 | Transmit error |

## Verification
The hardest situations to reach are an underrun at a chosen payload position and a true back-to-back pair of frames. An underrun needs the producer to withhold data after having promised a whole frame. A back-to-back pair needs `frame_avail` to stay high across the gap. The bench's byte source has a programmable stop index, so `s_valid` can drop before the first payload byte or in the middle of the payload. A separate run keeps `frame_avail` asserted for two frames and counts the idle cycles between them. A third run flips `cfg_raw` while a frame is on the wire, to show that the framing mode latched at frame start is the one that is used.

// File: rtl/usf_pkg.sv
package usf_pkg;

    localparam int PRE_LEN  = 8;
    localparam int ETH_LEN  = 14;
    localparam int IP_LEN   = 20;
    localparam int UDP_LEN  = 8;
    localparam int FCS_LEN  = 4;
    localparam int MIN_BODY = 60;
    localparam int FULL_HDR = ETH_LEN + IP_LEN + UDP_LEN;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_PAY,
        PH_PAD,
        PH_FCS,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [7:0] data;
        logic       en;
        logic       er;
    } beat_t;

    // One byte of reflected CRC-32, LSB of the byte first.
    function automatic logic [31:0] crc_next(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

    // IPv4 header checksum for the fixed header layout.
    function automatic logic [15:0] ip_hdr_csum(logic [15:0] tot, logic [7:0] ttl,
                                                logic [31:0] sip, logic [31:0] dip);
        logic [19:0] s;
        s = 20'h04500 + {4'h0, tot} + 20'h04000 + {4'h0, ttl, 8'h11}
          + {4'h0, sip[31:16]} + {4'h0, sip[15:0]}
          + {4'h0, dip[31:16]} + {4'h0, dip[15:0]};
        s = {4'h0, s[15:0]} + {16'h0, s[19:16]};
        s = {4'h0, s[15:0]} + {16'h0, s[19:16]};
        return ~s[15:0];
    endfunction

    function automatic int pad_for(int body);
        return (body >= MIN_BODY) ? 0 : (MIN_BODY - body);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/usf_hdr_rom.sv
module usf_hdr_rom
    import usf_pkg::*;
#(
    parameter int          PAY_LEN   = 32,
    parameter logic [47:0] DST_MAC   = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC   = 48'h02_AA_BB_CC_DD_EE,
    parameter logic [31:0] SRC_IP    = 32'hC0A8_0A01,
    parameter logic [31:0] DST_IP    = 32'hC0A8_0A02,
    parameter logic [15:0] SRC_PORT  = 16'd5000,
    parameter logic [15:0] DST_PORT  = 16'd6000,
    parameter logic [15:0] RAW_TYPE  = 16'h88B5,
    parameter logic [7:0]  IP_TTL    = 8'd64
) (
    input  logic [5:0] idx,
    input  logic       raw,
    output logic [7:0] hdr_byte
);

    localparam logic [15:0] TOT_LEN  = 16'(IP_LEN + UDP_LEN + PAY_LEN);
    localparam logic [15:0] DGRAM_LEN = 16'(UDP_LEN + PAY_LEN);
    localparam logic [15:0] IP_CSUM  = ip_hdr_csum(TOT_LEN, IP_TTL, SRC_IP, DST_IP);

    localparam logic [8*FULL_HDR-1:0] IMAGE = {
        DST_MAC, SRC_MAC, 16'h0800,
        8'h45, 8'h00, TOT_LEN, 16'h0000, 16'h4000, IP_TTL, 8'h11, IP_CSUM,
        SRC_IP, DST_IP,
        SRC_PORT, DST_PORT, DGRAM_LEN, 16'h0000
    };

    logic [7:0] tbl [FULL_HDR];

    for (genvar g = 0; g < FULL_HDR; g++) begin : g_tbl
        assign tbl[g] = IMAGE[8*(FULL_HDR-1-g) +: 8];
    end

    always_comb begin
        hdr_byte = 8'h00;
        if (raw && idx == 6'd12) begin
            hdr_byte = RAW_TYPE[15:8];
        end else if (raw && idx == 6'd13) begin
            hdr_byte = RAW_TYPE[7:0];
        end else if (int'(idx) < FULL_HDR) begin
            hdr_byte = tbl[idx];
        end
    end

endmodule

// File: rtl/usf_crc.sv
module usf_crc
    import usf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= crc_next(crc_q, din);
        end
    end

endmodule

// File: rtl/usf_seq.sv
module usf_seq
    import usf_pkg::*;
#(
    parameter int PAY_LEN = 32,
    parameter int GAP_LEN = 12,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_avail,
    input  logic             cfg_raw,
    input  logic             s_valid,
    output phase_e           ph,
    output logic [CNT_W-1:0] cnt,
    output logic             raw_q,
    output logic             s_ready
);

    localparam int PAD_UDP = pad_for(FULL_HDR + PAY_LEN);
    localparam int PAD_RAW = pad_for(ETH_LEN + PAY_LEN);

    logic [CNT_W-1:0] hdr_last;
    logic [CNT_W-1:0] pad_last;
    logic             pad_none;

    always_comb begin
        if (raw_q) begin
            hdr_last = CNT_W'(ETH_LEN - 1);
            pad_none = (PAD_RAW == 0);
            pad_last = (PAD_RAW == 0) ? '0 : CNT_W'(PAD_RAW - 1);
        end else begin
            hdr_last = CNT_W'(FULL_HDR - 1);
            pad_none = (PAD_UDP == 0);
            pad_last = (PAD_UDP == 0) ? '0 : CNT_W'(PAD_UDP - 1);
        end
    end

    assign s_ready = (ph == PH_PAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            raw_q <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (frame_avail) begin
                        ph    <= PH_PRE;
                        cnt   <= '0;
                        raw_q <= cfg_raw;
                    end
                end
                PH_PRE: begin
                    if (cnt == CNT_W'(PRE_LEN - 1)) begin
                        ph  <= PH_HDR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HDR: begin
                    if (cnt == hdr_last) begin
                        ph  <= PH_PAY;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PAY: begin
                    if (!s_valid) begin
                        ph  <= PH_GAP;
                        cnt <= '0;
                    end else if (cnt == CNT_W'(PAY_LEN - 1)) begin
                        ph  <= pad_none ? PH_FCS : PH_PAD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PAD: begin
                    if (cnt == pad_last) begin
                        ph  <= PH_FCS;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FCS: begin
                    if (cnt == CNT_W'(FCS_LEN - 1)) begin
                        ph  <= PH_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == CNT_W'(GAP_LEN - 1)) begin
                        cnt <= '0;
                        if (frame_avail) begin
                            ph    <= PH_PRE;
                            raw_q <= cfg_raw;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/udp_frame_streamer.sv
module udp_frame_streamer
    import usf_pkg::*;
#(
    parameter int          PAY_LEN   = 32,
    parameter int          GAP_LEN   = 12,
    parameter logic [47:0] DST_MAC   = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC   = 48'h02_AA_BB_CC_DD_EE,
    parameter logic [31:0] SRC_IP    = 32'hC0A8_0A01,
    parameter logic [31:0] DST_IP    = 32'hC0A8_0A02,
    parameter logic [15:0] SRC_PORT  = 16'd5000,
    parameter logic [15:0] DST_PORT  = 16'd6000,
    parameter logic [15:0] RAW_TYPE  = 16'h88B5,
    parameter logic [7:0]  IP_TTL    = 8'd64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_avail,
    input  logic       cfg_raw,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    output logic       s_ready,
    output logic [7:0] gmii_txd,
    output logic       gmii_tx_en,
    output logic       gmii_tx_er
);

    localparam int CNT_MAX = max2(max2(FULL_HDR, PAY_LEN), max2(GAP_LEN, MIN_BODY));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    phase_e           ph;
    logic [CNT_W-1:0] cnt;
    logic             raw_q;
    logic [7:0]       hdr_byte;
    logic [31:0]      crc_q;
    logic             crc_step;
    beat_t            beat;
    beat_t            beat_q;

    usf_seq #(
        .PAY_LEN (PAY_LEN),
        .GAP_LEN (GAP_LEN),
        .CNT_W   (CNT_W)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_avail (frame_avail),
        .cfg_raw     (cfg_raw),
        .s_valid     (s_valid),
        .ph          (ph),
        .cnt         (cnt),
        .raw_q       (raw_q),
        .s_ready     (s_ready)
    );

    usf_hdr_rom #(
        .PAY_LEN  (PAY_LEN),
        .DST_MAC  (DST_MAC),
        .SRC_MAC  (SRC_MAC),
        .SRC_IP   (SRC_IP),
        .DST_IP   (DST_IP),
        .SRC_PORT (SRC_PORT),
        .DST_PORT (DST_PORT),
        .RAW_TYPE (RAW_TYPE),
        .IP_TTL   (IP_TTL)
    ) i_hdr (
        .idx      (cnt[5:0]),
        .raw      (raw_q),
        .hdr_byte (hdr_byte)
    );

    usf_crc i_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (ph == PH_PRE),
        .step  (crc_step),
        .din   (beat.data),
        .crc_q (crc_q)
    );

    always_comb begin
        beat     = '0;
        crc_step = 1'b0;
        case (ph)
            PH_PRE: begin
                beat.en   = 1'b1;
                beat.data = (cnt == CNT_W'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
            end
            PH_HDR: begin
                beat.en   = 1'b1;
                beat.data = hdr_byte;
                crc_step  = 1'b1;
            end
            PH_PAY: begin
                beat.en = 1'b1;
                if (s_valid) begin
                    beat.data = s_data;
                    crc_step  = 1'b1;
                end else begin
                    beat.er = 1'b1;
                end
            end
            PH_PAD: begin
                beat.en  = 1'b1;
                crc_step = 1'b1;
            end
            PH_FCS: begin
                beat.en   = 1'b1;
                beat.data = ~crc_q[8*cnt[1:0] +: 8];
            end
            default: begin
                beat = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat;
        end
    end

    assign gmii_txd   = beat_q.data;
    assign gmii_tx_en = beat_q.en;
    assign gmii_tx_er = beat_q.er;

endmodule

// File: rtl/usf_checker.sv
module usf_checker #(
    parameter int GAP_LEN = 12
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] gmii_txd,
    input logic       gmii_tx_en,
    input logic       gmii_tx_er,
    input logic       s_ready
);

    localparam int IW = $clog2(GAP_LEN + 1) + 1;

    logic [IW-1:0] idle_cnt;
    logic          ended;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            ended    <= 1'b0;
        end else begin
            if (gmii_tx_en) begin
                idle_cnt <= '0;
            end else if (idle_cnt != IW'(GAP_LEN)) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (gmii_tx_en) begin
                ended <= 1'b1;
            end
        end
    end

    // R9: the error line is only raised inside a frame
    a_r9_er_inside_frame: assert property (@(posedge clk) disable iff (rst)
        gmii_tx_er |-> gmii_tx_en);

    // R9: an errored byte is the last byte of its frame
    a_r9_er_ends_frame: assert property (@(posedge clk) disable iff (rst)
        (gmii_tx_en && gmii_tx_er) |=> !gmii_tx_en);

    // R4: payload is only taken while a frame is on the wire
    a_r4_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> gmii_tx_en);

    // R2: a frame opens with a preamble byte
    a_r2_opens_with_preamble: assert property (@(posedge clk) disable iff (rst)
        $rose(gmii_tx_en) |-> (gmii_txd == 8'h55));

    // R8: minimum idle gap between frames
    a_r8_min_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(gmii_tx_en) && ended) |-> (idle_cnt == IW'(GAP_LEN)));

endmodule

bind udp_frame_streamer usf_checker #(.GAP_LEN(GAP_LEN)) i_usf_checker (
    .clk        (clk),
    .rst        (rst),
    .gmii_txd   (gmii_txd),
    .gmii_tx_en (gmii_tx_en),
    .gmii_tx_er (gmii_tx_er),
    .s_ready    (s_ready)
);

// File: tb/test_udp_frame_streamer.sv
module test_udp_frame_streamer;

    localparam int          PAY   = 32;
    localparam int          GAP   = 12;
    localparam logic [47:0] DMAC  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SMAC  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [31:0] SIP   = 32'hC0A8_0A01;
    localparam logic [31:0] DIP   = 32'hC0A8_0A02;
    localparam logic [15:0] SPORT = 16'd5000;
    localparam logic [15:0] DPORT = 16'd6000;
    localparam logic [15:0] RTYPE = 16'h88B5;
    localparam logic [7:0]  TTL   = 8'd64;

    // vector: {raw[16], underrun_at[15:8] (0 = none, k+1 = stop after k bytes), seed[7:0]}
    localparam int NVEC = 6;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'd0, 8'h11},
        {1'b1, 8'd0, 8'h3C},
        {1'b0, 8'd0, 8'hA5},
        {1'b1, 8'd0, 8'hFF},
        {1'b0, 8'd6, 8'h20},
        {1'b1, 8'd1, 8'h40}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_avail = 1'b0;
    logic       cfg_raw = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] gmii_txd;
    logic       gmii_tx_en;
    logic       gmii_tx_er;

    int nvec  = 0;
    int nfail = 0;

    logic [7:0] cap   [256];
    logic       caper [256];
    int         caplen;
    logic [7:0] exp_b [256];
    int         explen;
    logic [7:0] pay   [PAY];
    bit         stop_drv;

    always #2 clk = ~clk;

    udp_frame_streamer #(
        .PAY_LEN  (PAY),
        .GAP_LEN  (GAP),
        .DST_MAC  (DMAC),
        .SRC_MAC  (SMAC),
        .SRC_IP   (SIP),
        .DST_IP   (DIP),
        .SRC_PORT (SPORT),
        .DST_PORT (DPORT),
        .RAW_TYPE (RTYPE),
        .IP_TTL   (TTL)
    ) i_udp_frame_streamer (
        .clk         (clk),
        .rst         (rst),
        .frame_avail (frame_avail),
        .cfg_raw     (cfg_raw),
        .s_data      (s_data),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .gmii_txd    (gmii_txd),
        .gmii_tx_en  (gmii_tx_en),
        .gmii_tx_er  (gmii_tx_er)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b);
        exp_b[explen] = b;
        explen++;
    endtask

    task automatic push16(input logic [15:0] w);
        push(w[15:8]);
        push(w[7:0]);
    endtask

    task automatic build_expected(input bit raw, input logic [7:0] seed);
        logic [31:0] c;
        logic [19:0] s;
        logic [7:0]  b;
        int          body_end;
        explen = 0;
        for (int i = 0; i < PAY; i++) pay[i] = seed + 8'(i * 7);
        for (int i = 0; i < 7; i++) push(8'h55);
        push(8'hD5);
        for (int i = 5; i >= 0; i--) push(DMAC[8*i +: 8]);
        for (int i = 5; i >= 0; i--) push(SMAC[8*i +: 8]);
        if (raw) begin
            push16(RTYPE);
        end else begin
            push16(16'h0800);
            push(8'h45); push(8'h00);
            push16(16'(28 + PAY));
            push16(16'h0000); push16(16'h4000);
            push(TTL); push(8'h11);
            push16(16'h0000);
            push16(SIP[31:16]); push16(SIP[15:0]);
            push16(DIP[31:16]); push16(DIP[15:0]);
            push16(SPORT); push16(DPORT);
            push16(16'(8 + PAY)); push16(16'h0000);
            s = '0;
            for (int i = 22; i < 42; i += 2) s = s + {4'h0, exp_b[i], exp_b[i+1]};
            s = {4'h0, s[15:0]} + {16'h0, s[19:16]};
            s = {4'h0, s[15:0]} + {16'h0, s[19:16]};
            exp_b[32] = ~s[15:8];
            exp_b[33] = ~s[7:0];
        end
        for (int i = 0; i < PAY; i++) push(pay[i]);
        while (explen < 8 + 60) push(8'h00);
        body_end = explen;
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < body_end; i++) begin
            b = exp_b[i];
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB8_8320;
                else             c = c >> 1;
            end
        end
        c = ~c;
        for (int i = 0; i < 4; i++) push(c[8*i +: 8]);
    endtask

    task automatic capture(input bit drop_avail);
        caplen = 0;
        while (!gmii_tx_en) @(negedge clk);
        if (drop_avail) frame_avail = 1'b0;
        while (gmii_tx_en) begin
            if (caplen < 256) begin
                cap[caplen]   = gmii_txd;
                caper[caplen] = gmii_tx_er;
            end
            caplen++;
            @(negedge clk);
        end
    endtask

    task automatic drive(input int under);
        int idx = 0;
        while (!stop_drv) begin
            @(negedge clk);
            if (!gmii_tx_en) idx = 0;
            if (under != 0 && idx >= under - 1) begin
                s_valid = 1'b0;
            end else if (idx < PAY) begin
                s_valid = 1'b1;
                s_data  = pay[idx];
            end else begin
                s_valid = 1'b0;
            end
            if (s_ready && s_valid) idx++;
        end
        s_valid = 1'b0;
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int i = lo; i < hi; i++) begin
            if (i >= caplen || cap[i] !== exp_b[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, {what, " byte"}, (first < caplen) ? int'(cap[first]) : -1,
                 int'(exp_b[first]));
    endtask

    task automatic compare_frame(input bit raw, input int under);
        int    hlen = raw ? 14 : 42;
        string hreq = raw ? "R6" : "R3";
        int    ercount = 0;
        for (int i = 0; i < caplen && i < 256; i++) if (caper[i]) ercount++;
        if (under == 0) begin
            chk(caplen == explen, raw ? "R6" : "R4", "frame length", caplen, explen);
            cmp_range(0, 8, "R2", "preamble");
            cmp_range(8, 8 + hlen, hreq, "header");
            cmp_range(8 + hlen, 8 + hlen + PAY, "R4", "payload");
            if (raw) cmp_range(8 + hlen + PAY, explen - 4, "R6", "padding");
            cmp_range(explen - 4, explen, "R5", "fcs");
            chk(ercount == 0, "R9", "error flags in clean frame", ercount, 0);
        end else begin
            chk(caplen == 8 + hlen + under, "R9", "underrun frame length",
                caplen, 8 + hlen + under);
            chk(ercount == 1 && caper[caplen-1], "R9", "error on last byte only", ercount, 1);
            cmp_range(0, 8 + hlen + under - 1, "R4", "bytes before underrun");
        end
    endtask

    task automatic run_vec(input bit raw, input int under, input logic [7:0] seed);
        build_expected(raw, seed);
        cfg_raw     = raw;
        stop_drv    = 1'b0;
        frame_avail = 1'b1;
        fork
            begin capture(1'b1); stop_drv = 1'b1; end
            drive(under);
        join
        repeat (20) @(negedge clk);
        compare_frame(raw, under);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int gap;
        int seen;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!gmii_tx_en && !gmii_tx_er && gmii_txd == 8'h00 && !s_ready, "R1",
            "outputs in reset", {gmii_tx_en, gmii_tx_er, s_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!gmii_tx_en && !gmii_tx_er && gmii_txd == 8'h00 && !s_ready, "R1",
            "outputs after reset", {gmii_tx_en, gmii_tx_er, s_ready}, 0);

        // R7: no frame without frame_avail
        seen = 0;
        s_valid = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (gmii_tx_en) seen++;
        end
        s_valid = 1'b0;
        chk(seen == 0, "R7", "idle without frame_avail", seen, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0]);
        end

        // R8: back-to-back frames, exact gap
        build_expected(1'b0, 8'h77);
        cfg_raw     = 1'b0;
        stop_drv    = 1'b0;
        frame_avail = 1'b1;
        gap         = 0;
        fork
            begin
                capture(1'b0);
                while (!gmii_tx_en) begin gap++; @(negedge clk); end
                capture(1'b1);
                stop_drv = 1'b1;
            end
            drive(0);
        join
        repeat (20) @(negedge clk);
        chk(gap == GAP, "R8", "back-to-back idle gap", gap, GAP);
        compare_frame(1'b0, 0);

        // R10: mode change during a frame is ignored
        build_expected(1'b0, 8'h5A);
        cfg_raw     = 1'b0;
        stop_drv    = 1'b0;
        frame_avail = 1'b1;
        fork
            begin capture(1'b1); stop_drv = 1'b1; end
            drive(0);
            begin
                while (!gmii_tx_en) @(negedge clk);
                cfg_raw = 1'b1;
            end
        join
        repeat (20) @(negedge clk);
        chk(caplen == explen, "R10", "frame length after mid-frame mode flip", caplen, explen);
        compare_frame(1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule